// File: doc/BRIEF.md
# Cascadable Slice Arithmetic/Logic Core

This block is the combinational arithmetic and logic core of a narrow, cascadable datapath slice. Each cycle a 3-bit source code chooses the two ALU operands, R and S, from the A-port and B-port register data, the direct data input, the Q register value, or a constant zero. A 3-bit function code then picks one of three arithmetic operations or five bitwise operations. The result and its flags appear on the outputs in the same cycle. Register storage, shifting and the carry-lookahead generator sit outside the block.

Slices are chained to build wider words. Every slice reports active-low group generate and propagate terms, which an external lookahead unit turns into the carry-in of the next slice. The most significant slice supplies carry-out, overflow and sign. The zero flags of all slices are ANDed to give word-level zero detection. Subtraction is done by complementing one operand and adding the carry-in. With carry-in high, the result is the exact two's-complement difference. With carry-in low, it is one less.

Top module: `slice_alu`

## Requirements
- R1: Operand pair (R,S) by source code: 0 gives (A,Q), 1 gives (A,B), 2 gives (0,Q), 3 gives (0,B), 4 gives (0,A), 5 gives (D,A), 6 gives (D,Q), 7 gives (D,0).
- R2: Logic functions by function code: 3 gives R OR S, 4 gives R AND S, 5 gives (NOT R) AND S, 6 gives R XOR S, 7 gives NOT (R XOR S).
- R3: Arithmetic functions by function code, all with carry-in Cn added: 0 gives R+S+Cn, 1 gives S+~R+Cn (S-R when Cn=1, S-R-1 when Cn=0), 2 gives R+~S+Cn. The result is taken modulo 2^WIDTH.
- R4: In the logic codes (3 to 7), carry-in does not change the result, and carry_out and overflow are both low.
- R5: In the arithmetic codes (0 to 2), overflow is the XOR of the carry into the MSB and the carry out of the MSB, and carry_out is the carry out of the MSB.
- R6: The zero flag is high exactly when every result bit is low.
- R7: The sign output equals the MSB of the result.
- R8: In the arithmetic codes, gen_n and prop_n are the active-low group generate and propagate of the effective adder operands, so that carry_out = !gen_n OR (!prop_n AND carry_in). In the logic codes, both are high.
- R9: Four slices chained through an external lookahead unit produce the correct 16-bit result, carry, overflow, sign and zero for every code pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_sel | input | 3 | Operand source code (R1) |
| fn_sel | input | 3 | ALU function code (R2, R3) |
| a_data | input | WIDTH | A-port register data |
| b_data | input | WIDTH | B-port register data |
| d_data | input | WIDTH | Direct data input |
| q_data | input | WIDTH | Q register data |
| carry_in | input | 1 | Carry-in, active high |
| f_out | output | WIDTH | ALU result |
| carry_out | output | 1 | Carry out of the MSB, active high |
| gen_n | output | 1 | Group generate, active low |
| prop_n | output | 1 | Group propagate, active low |
| ovf | output | 1 | Two's-complement overflow |
| sign | output | 1 | Result MSB |
| zero | output | 1 | High when the result is all zeros |

## Verification
The bench drives four slices joined by a lookahead model and compares each result with a 16-bit reference, over every source and function pair, with random operands and both carry-in values. Directed cases cover several kinds of error:
- Overflow at the positive and negative limits, which a design that takes the carry from the wrong bit would misreport.
- Subtraction with carry-in low and high, where a swapped operand complement gives the negated difference.
- Logic functions issued with both carry-in values, where a leaking carry changes F or raises carry_out.
- Carries that must ripple across all four slices, which fail if generate or propagate is built from the raw operands instead of the effective (complemented) ones.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

    typedef enum logic [2:0] {
        SRC_AQ = 3'd0,
        SRC_AB = 3'd1,
        SRC_ZQ = 3'd2,
        SRC_ZB = 3'd3,
        SRC_ZA = 3'd4,
        SRC_DA = 3'd5,
        SRC_DQ = 3'd6,
        SRC_DZ = 3'd7
    } src_code_e;

    typedef enum logic [2:0] {
        FN_ADD   = 3'd0,
        FN_SMINR = 3'd1,
        FN_RMINS = 3'd2,
        FN_OR    = 3'd3,
        FN_AND   = 3'd4,
        FN_NRAND = 3'd5,
        FN_XOR   = 3'd6,
        FN_XNOR  = 3'd7
    } fn_code_e;

    function automatic logic is_arith(input logic [2:0] fn);
        return (fn == FN_ADD) || (fn == FN_SMINR) || (fn == FN_RMINS);
    endfunction

endpackage

// File: rtl/slice_operand_sel.sv
module slice_operand_sel
    import slice_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [2:0]       src_sel,
    input  logic [WIDTH-1:0] a_data,
    input  logic [WIDTH-1:0] b_data,
    input  logic [WIDTH-1:0] d_data,
    input  logic [WIDTH-1:0] q_data,
    output logic [WIDTH-1:0] r_op,
    output logic [WIDTH-1:0] s_op
);
    localparam logic [WIDTH-1:0] ZERO = '0;

    always_comb begin
        unique case (src_code_e'(src_sel))
            SRC_AQ: begin r_op = a_data; s_op = q_data; end
            SRC_AB: begin r_op = a_data; s_op = b_data; end
            SRC_ZQ: begin r_op = ZERO;   s_op = q_data; end
            SRC_ZB: begin r_op = ZERO;   s_op = b_data; end
            SRC_ZA: begin r_op = ZERO;   s_op = a_data; end
            SRC_DA: begin r_op = d_data; s_op = a_data; end
            SRC_DQ: begin r_op = d_data; s_op = q_data; end
            SRC_DZ: begin r_op = d_data; s_op = ZERO;   end
            default: begin r_op = ZERO;  s_op = ZERO;   end
        endcase
    end
endmodule

// File: rtl/slice_adder.sv
module slice_adder #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_op,
    input  logic [WIDTH-1:0] y_op,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             c_msb,
    output logic             grp_gen,
    output logic             grp_prop
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] bit_gen;
    logic [WIDTH-1:0] bit_prop;

    assign carry[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign bit_gen[i]  = x_op[i] & y_op[i];
        assign bit_prop[i] = x_op[i] | y_op[i];
        assign sum[i]      = x_op[i] ^ y_op[i] ^ carry[i];
        assign carry[i+1]  = bit_gen[i] | (bit_prop[i] & carry[i]);
    end

    assign cout  = carry[WIDTH];
    assign c_msb = carry[MSB];

    always_comb begin
        grp_gen = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            grp_gen = bit_gen[i] | (bit_prop[i] & grp_gen);
        end
        grp_prop = &bit_prop;
    end
endmodule

// File: rtl/slice_logic_unit.sv
module slice_logic_unit
    import slice_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [2:0]       fn_sel,
    input  logic [WIDTH-1:0] r_op,
    input  logic [WIDTH-1:0] s_op,
    output logic [WIDTH-1:0] l_out
);
    always_comb begin
        unique case (fn_code_e'(fn_sel))
            FN_OR:    l_out = r_op | s_op;
            FN_AND:   l_out = r_op & s_op;
            FN_NRAND: l_out = ~r_op & s_op;
            FN_XOR:   l_out = r_op ^ s_op;
            FN_XNOR:  l_out = ~(r_op ^ s_op);
            default:  l_out = '0;
        endcase
    end
endmodule

// File: rtl/slice_alu.sv
module slice_alu
    import slice_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [2:0]       src_sel,
    input  logic [2:0]       fn_sel,
    input  logic [WIDTH-1:0] a_data,
    input  logic [WIDTH-1:0] b_data,
    input  logic [WIDTH-1:0] d_data,
    input  logic [WIDTH-1:0] q_data,
    input  logic             carry_in,
    output logic [WIDTH-1:0] f_out,
    output logic             carry_out,
    output logic             gen_n,
    output logic             prop_n,
    output logic             ovf,
    output logic             sign,
    output logic             zero
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] r_op, s_op, x_op, y_op, sum, l_out;
    logic             cout, c_msb, grp_gen, grp_prop, arith;

    slice_operand_sel #(.WIDTH(WIDTH)) u_sel (
        .src_sel(src_sel), .a_data(a_data), .b_data(b_data),
        .d_data(d_data), .q_data(q_data), .r_op(r_op), .s_op(s_op)
    );

    assign arith = is_arith(fn_sel);

    always_comb begin
        unique case (fn_code_e'(fn_sel))
            FN_SMINR: begin x_op = ~r_op; y_op = s_op;  end
            FN_RMINS: begin x_op = r_op;  y_op = ~s_op; end
            default:  begin x_op = r_op;  y_op = s_op;  end
        endcase
    end

    slice_adder #(.WIDTH(WIDTH)) u_add (
        .x_op(x_op), .y_op(y_op), .cin(carry_in), .sum(sum),
        .cout(cout), .c_msb(c_msb), .grp_gen(grp_gen), .grp_prop(grp_prop)
    );

    slice_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .fn_sel(fn_sel), .r_op(r_op), .s_op(s_op), .l_out(l_out)
    );

    assign f_out     = arith ? sum : l_out;
    assign carry_out = arith & cout;
    assign ovf       = arith & (cout ^ c_msb);
    assign gen_n     = ~(arith & grp_gen);
    assign prop_n    = ~(arith & grp_prop);
    assign sign      = f_out[MSB];
    assign zero      = ~|f_out;
endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
    parameter int WIDTH = 4
) (
    input logic [2:0]       src_sel,
    input logic [2:0]       fn_sel,
    input logic [WIDTH-1:0] d_data,
    input logic             carry_in,
    input logic [WIDTH-1:0] f_out,
    input logic             carry_out,
    input logic             gen_n,
    input logic             prop_n,
    input logic             ovf,
    input logic             sign,
    input logic             zero
);
    localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {(WIDTH-1){1'b1}}};

    always_comb begin
        // R4: logic codes keep carry and overflow low
        if (fn_sel >= 3'd3)
            a_r4_logic_quiet: assert (!carry_out && !ovf);
        // R8: lookahead terms agree with the ripple carry
        if (fn_sel <= 3'd2)
            a_r8_lookahead: assert (carry_out == (!gen_n || (!prop_n && carry_in)));
        else
            a_r8_logic_inactive: assert (gen_n && prop_n);
        // R7: sign follows the result MSB
        a_r7_sign: assert (sign == f_out[WIDTH-1]);
        // R6: D AND 0 always gives a zero result
        if (fn_sel == 3'd4 && src_sel == 3'd7)
            a_r6_and_zero: assert (zero && f_out == '0);
        // R5: D plus 0 plus Cn overflows only at the positive limit with Cn set
        if (fn_sel == 3'd0 && src_sel == 3'd7)
            a_r5_add_ovf: assert (ovf == (d_data == MAX_POS && carry_in));
    end
endmodule

bind slice_alu slice_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .src_sel(src_sel), .fn_sel(fn_sel), .d_data(d_data), .carry_in(carry_in),
    .f_out(f_out), .carry_out(carry_out), .gen_n(gen_n), .prop_n(prop_n),
    .ovf(ovf), .sign(sign), .zero(zero)
);

// File: tb/slice_alu_tb.sv
`timescale 1ns/1ps
module slice_alu_tb;
    localparam int SLICES = 4;
    localparam int SW     = 4;
    localparam int WW     = SLICES * SW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [2:0]    src, fn;
    logic [WW-1:0] a16, b16, d16, q16;
    logic          cin;

    logic [WW-1:0]     f16;
    logic [SLICES:0]   c;
    logic [SLICES-1:0] co, gn, pn, ov, sg, zr;

    int checks = 0;
    int errors = 0;

    assign c[0] = cin;
    for (genvar k = 0; k < SLICES; k++) begin : g_slice
        slice_alu #(.WIDTH(SW)) u_dut (
            .src_sel(src), .fn_sel(fn),
            .a_data(a16[k*SW +: SW]), .b_data(b16[k*SW +: SW]),
            .d_data(d16[k*SW +: SW]), .q_data(q16[k*SW +: SW]),
            .carry_in(c[k]), .f_out(f16[k*SW +: SW]), .carry_out(co[k]),
            .gen_n(gn[k]), .prop_n(pn[k]), .ovf(ov[k]), .sign(sg[k]), .zero(zr[k])
        );
        assign c[k+1] = ~gn[k] | (~pn[k] & c[k]);
    end

    typedef struct packed {
        logic [WW-1:0] f;
        logic          cout;
        logic          ovf;
    } ref_t;

    function automatic ref_t ref_eval(input logic [2:0] s_code, input logic [2:0] f_code,
                                      input logic [WW-1:0] a, input logic [WW-1:0] b,
                                      input logic [WW-1:0] d, input logic [WW-1:0] q,
                                      input logic ci);
        logic [WW-1:0] r, s, x, y;
        logic [WW:0]   full;
        logic [WW-1:0] low;
        ref_t o;
        case (s_code)
            3'd0: begin r = a;  s = q;  end
            3'd1: begin r = a;  s = b;  end
            3'd2: begin r = '0; s = q;  end
            3'd3: begin r = '0; s = b;  end
            3'd4: begin r = '0; s = a;  end
            3'd5: begin r = d;  s = a;  end
            3'd6: begin r = d;  s = q;  end
            default: begin r = d; s = '0; end
        endcase
        o = '0;
        if (f_code <= 3'd2) begin
            x = (f_code == 3'd1) ? ~r : r;
            y = (f_code == 3'd2) ? ~s : s;
            full = {1'b0, x} + {1'b0, y} + {{WW{1'b0}}, ci};
            low  = {1'b0, x[WW-2:0]} + {1'b0, y[WW-2:0]} + {{(WW-1){1'b0}}, ci};
            o.f = full[WW-1:0];
            o.cout = full[WW];
            o.ovf = full[WW] ^ low[WW-1];
        end else begin
            case (f_code)
                3'd3: o.f = r | s;
                3'd4: o.f = r & s;
                3'd5: o.f = ~r & s;
                3'd6: o.f = r ^ s;
                default: o.f = ~(r ^ s);
            endcase
        end
        return o;
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s src=%0d fn=%0d cin=%0b actual=%h expected=%h",
                     req, what, src, fn, cin, act, exp);
        end
    endtask

    task automatic run_case(input logic [2:0] s_code, input logic [2:0] f_code,
                            input logic [WW-1:0] a, input logic [WW-1:0] b,
                            input logic [WW-1:0] d, input logic [WW-1:0] q, input logic ci);
        ref_t e;
        logic arith;
        @(posedge clk);
        src = s_code; fn = f_code; a16 = a; b16 = b; d16 = d; q16 = q; cin = ci;
        @(negedge clk);
        e = ref_eval(s_code, f_code, a, b, d, q, ci);
        arith = (f_code <= 3'd2);
        chk(f16 == e.f, arith ? "R1/R3/R9" : "R1/R2/R9", "result", f16, e.f);
        chk(sg[SLICES-1] == e.f[WW-1], "R7", "sign", WW'(sg[SLICES-1]), WW'(e.f[WW-1]));
        chk((&zr) == (e.f == '0), "R6", "zero", WW'(&zr), WW'(e.f == '0));
        if (arith) begin
            chk(co[SLICES-1] == e.cout, "R5", "carry_out", WW'(co[SLICES-1]), WW'(e.cout));
            chk(c[SLICES] == e.cout, "R8", "lookahead carry", WW'(c[SLICES]), WW'(e.cout));
            chk(ov[SLICES-1] == e.ovf, "R5", "overflow", WW'(ov[SLICES-1]), WW'(e.ovf));
        end else begin
            chk(co == '0 && ov == '0, "R4", "logic carry/ovf", WW'({co, ov}), '0);
            chk(&gn && &pn, "R8", "logic gen/prop", WW'({gn, pn}), WW'(8'hFF));
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [WW-1:0] f_lo, f_hi;
        void'($urandom(32'd2901));
        src = 3'd7; fn = 3'd0; a16 = '0; b16 = '0; d16 = '0; q16 = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(f16 == '0 && (&zr), "R6", "reset state zero", f16, '0);

        // R5 directed: positive limit plus one, negative limit minus one
        run_case(3'd7, 3'd0, '0, '0, 16'h7FFF, '0, 1'b1);
        run_case(3'd5, 3'd0, 16'h8000, '0, 16'hFFFF, '0, 1'b0);
        // R3 subtraction with both carry-in values
        run_case(3'd1, 3'd1, 16'h0003, 16'h0010, '0, '0, 1'b1);
        run_case(3'd1, 3'd1, 16'h0003, 16'h0010, '0, '0, 1'b0);
        run_case(3'd1, 3'd2, 16'h0003, 16'h0010, '0, '0, 1'b1);
        run_case(3'd1, 3'd2, 16'h8000, 16'h0001, '0, '0, 1'b1);
        // R9 full ripple across all slices
        run_case(3'd1, 3'd0, 16'hFFFF, 16'h0000, '0, '0, 1'b1);
        run_case(3'd2, 3'd1, '0, '0, '0, 16'h0000, 1'b1);

        // R4 carry-in has no effect in logic codes
        for (int f = 3; f < 8; f++) begin
            run_case(3'd1, 3'(f), 16'h5A3C, 16'h0FF0, '0, '0, 1'b0);
            f_lo = f16;
            run_case(3'd1, 3'(f), 16'h5A3C, 16'h0FF0, '0, '0, 1'b1);
            f_hi = f16;
            chk(f_lo == f_hi, "R4", "cin effect in logic", f_hi, f_lo);
        end

        // R1 R2 R3 random sweep over every code pair
        for (int it = 0; it < 24; it++) begin
            for (int s = 0; s < 8; s++) begin
                for (int f = 0; f < 8; f++) begin
                    run_case(3'(s), 3'(f), WW'($urandom), WW'($urandom),
                             WW'($urandom), WW'($urandom), 1'($urandom));
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule